// File: doc/BRIEF.md
# Dual Comparator Output Controller

This block is the digital side of a pair of analog comparators. Each channel has one 32-bit configuration word on a simple strobe bus. The word sets the enable, the output polarity, the blanking source, window operation and the analog input selections. Software can lock the word, and the lock holds until reset. The block takes each raw comparator decision and forces it low when the channel is disabled. It then applies the polarity and masks the result with the selected timer blanking pulses. The channel output is either that value or, in window operation, the XOR of both channels.

The external outputs stay combinational from the raw comparator pins, so that a break or shutdown path reacts quickly. The live output bit that software reads comes through a two-flop synchronizer. The analog multiplexer selects, the hysteresis and speed codes and the reference scaler enable are driven out as levels for the analog macro.

Top module: `cmpw_ctrl`

## Requirements
- R1: After reset both configuration words read 0. Bits 29:25, 13:12, 10 and 3:1 always read 0. A read strobe loads `bus_rdata` at the next clock edge. Word address 0 is channel 0 and word address 1 is channel 1.
- R2: Bit 31 is a lock. Writing 1 to it sets it. While it is 1, every write to that word is ignored, including a write that clears bit 31. Only reset clears the lock.
- R3: The writable fields are: enable at bit 0, inverting input select at 7:4, noninverting input select at 9:8, window input link at 11, window output at 14, polarity at 15, hysteresis at 17:16, speed code at 19:18 and blanking select at 24:20. Each reads back as written.
- R4: With the enable bit at 0, the raw decision is taken as 0, so before blanking the channel value equals the polarity bit.
- R5: With the enable bit at 1, the channel value is the raw decision when polarity is 0 and its inverse when polarity is 1.
- R6: Blanking select bits 0, 1 and 2 choose `blank_src[3*ch+0..2]`. The chosen sources are ORed into a mask, and a high mask forces the channel value to 0. Select bits 3 and 4 pick no source.
- R7: Bit 30 reads the channel value computed from the raw input after two synchronizer flops. A raw change is therefore visible to a read strobe issued two clock edges later.
- R8: `cmp_out[ch]` is combinational. It is the channel's own value when bit 14 is 0, and the XOR of both channel values when bit 14 is 1.
- R9: `inp_sel[2*ch+:2]` is the other channel's noninverting select when bit 11 is set, and the channel's own select otherwise. `inp_link[ch]` equals bit 11.
- R10: `scaler_en` is 1 when an enabled channel has an inverting select code of 0 to 3, and 0 otherwise.
- R11: `inm_sel`, `hyst_sel`, `pwr_sel` and `cmp_en` drive the stored fields of each channel, packed per channel with channel 0 in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Word address (channel index) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cmp_raw | input | 2 | Raw asynchronous comparator decisions |
| blank_src | input | 2*NBLK | Timer compare pulses, NBLK per channel |
| cmp_out | output | 2 | Fast combinational channel outputs |
| inp_sel | output | 4 | Effective noninverting input select per channel |
| inp_link | output | 2 | Noninverting input shared with the other channel |
| inm_sel | output | 8 | Inverting input select per channel |
| hyst_sel | output | 4 | Hysteresis code per channel |
| pwr_sel | output | 4 | Speed/power code per channel |
| cmp_en | output | 2 | Channel enable to the analog macro |
| scaler_en | output | 1 | Reference divider enable |

## Verification
The bench builds the block with its defaults: NBLK of 3, SYNC_STAGES of 2 and ADDR_W of 1. With three blanking sources per channel, every valid select bit and the two select bits that pick no source can be reached. With two synchronizer stages, the read-back delay is short and exact, so every readback can be compared against the value from three cycles earlier. Random configuration words, raw levels and blanking pulses cover combinations of polarity, enable and window output. Directed cases cover lock persistence across writes and reset, window linking of the inputs and the disabled-channel polarity rule.

// File: rtl/cmpw_pkg.sv
package cmpw_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BLK_W  = 5;
  localparam int unsigned INM_W  = 4;
  localparam int unsigned INP_W  = 2;
  localparam int unsigned PWR_W  = 2;
  localparam int unsigned HYS_W  = 2;

  localparam int unsigned B_LOCK   = 31;
  localparam int unsigned B_VALUE  = 30;
  localparam int unsigned B_BLK    = 20;
  localparam int unsigned B_PWR    = 18;
  localparam int unsigned B_HYS    = 16;
  localparam int unsigned B_POL    = 15;
  localparam int unsigned B_WOUT   = 14;
  localparam int unsigned B_WLINK  = 11;
  localparam int unsigned B_INP    = 8;
  localparam int unsigned B_INM    = 4;
  localparam int unsigned B_EN     = 0;

  // inverting select codes at or below this value route the divided reference
  localparam logic [INM_W-1:0] INM_REF_MAX = 4'd3;

  // bits that may ever read as 1 (stored fields plus the live value)
  localparam logic [WORD_W-1:0] LIVE_BITS = 32'hC1FF_CBF1;

  typedef struct packed {
    logic             lock;
    logic [BLK_W-1:0] blank;
    logic [PWR_W-1:0] pwr;
    logic [HYS_W-1:0] hys;
    logic             pol;
    logic             wout;
    logic             wlink;
    logic [INP_W-1:0] inp;
    logic [INM_W-1:0] inm;
    logic             en;
  } cmp_cfg_t;

  function automatic cmp_cfg_t word_to_cfg(logic [WORD_W-1:0] w);
    cmp_cfg_t c;
    c.lock  = w[B_LOCK];
    c.blank = w[B_BLK +: BLK_W];
    c.pwr   = w[B_PWR +: PWR_W];
    c.hys   = w[B_HYS +: HYS_W];
    c.pol   = w[B_POL];
    c.wout  = w[B_WOUT];
    c.wlink = w[B_WLINK];
    c.inp   = w[B_INP +: INP_W];
    c.inm   = w[B_INM +: INM_W];
    c.en    = w[B_EN];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(cmp_cfg_t c, logic live);
    logic [WORD_W-1:0] w;
    w                   = '0;
    w[B_LOCK]           = c.lock;
    w[B_VALUE]          = live;
    w[B_BLK +: BLK_W]   = c.blank;
    w[B_PWR +: PWR_W]   = c.pwr;
    w[B_HYS +: HYS_W]   = c.hys;
    w[B_POL]            = c.pol;
    w[B_WOUT]           = c.wout;
    w[B_WLINK]          = c.wlink;
    w[B_INP +: INP_W]   = c.inp;
    w[B_INM +: INM_W]   = c.inm;
    w[B_EN]             = c.en;
    return w;
  endfunction
endpackage

// File: rtl/cmpw_sync.sv
module cmpw_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign q[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/cmpw_cfg_reg.sv
module cmpw_cfg_reg
  import cmpw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wdata,
  output cmp_cfg_t          cfg_q
);
  cmp_cfg_t cfg_d;
  logic     cfg_ce;

  // locked words accept nothing, so the lock bit itself becomes set-only
  always_comb begin
    cfg_ce = wr_hit && !cfg_q.lock;
    cfg_d  = word_to_cfg(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_ce) cfg_q <= cfg_d;
  end

  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> cfg_q.lock);

  a_r2_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> $stable(cfg_q));
endmodule

// File: rtl/cmpw_gate.sv
module cmpw_gate #(
  parameter int unsigned NBLK = 3
) (
  input  logic            raw,
  input  logic            en,
  input  logic            pol,
  input  logic [NBLK-1:0] blank_sel,
  input  logic [NBLK-1:0] blank_src,
  output logic            value
);
  logic gated;
  logic polar;
  logic mask;

  always_comb begin
    gated = raw & en;
    polar = gated ^ pol;
    mask  = |(blank_sel & blank_src);
    value = polar & ~mask;
  end
endmodule

// File: rtl/cmpw_ctrl.sv
module cmpw_ctrl
  import cmpw_pkg::*;
#(
  parameter int unsigned NBLK        = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [1:0]           cmp_raw,
  input  logic [2*NBLK-1:0]    blank_src,
  output logic [1:0]           cmp_out,
  output logic [3:0]           inp_sel,
  output logic [1:0]           inp_link,
  output logic [7:0]           inm_sel,
  output logic [3:0]           hyst_sel,
  output logic [3:0]           pwr_sel,
  output logic [1:0]           cmp_en,
  output logic                 scaler_en
);
  localparam int unsigned NCH = 2;

  cmp_cfg_t          cfg_q [NCH];
  logic [NCH-1:0]    raw_sync;
  logic [NCH-1:0]    fast_val;
  logic [NCH-1:0]    slow_val;
  logic [NCH-1:0]    ref_use;
  logic [WORD_W-1:0] rdata_d;

  cmpw_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cmp_raw),
    .q     (raw_sync)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int unsigned OTHER = NCH - 1 - g;
    logic wr_hit;

    assign wr_hit = bus_wr && (bus_addr == ADDR_W'(g));

    cmpw_cfg_reg u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit),
      .wdata  (bus_wdata),
      .cfg_q  (cfg_q[g])
    );

    // fast path straight from the comparator pin, for shutdown logic
    cmpw_gate #(.NBLK(NBLK)) u_fast (
      .raw       (cmp_raw[g]),
      .en        (cfg_q[g].en),
      .pol       (cfg_q[g].pol),
      .blank_sel (cfg_q[g].blank[NBLK-1:0]),
      .blank_src (blank_src[g*NBLK +: NBLK]),
      .value     (fast_val[g])
    );

    // slow path from the synchronizer, for software readback
    cmpw_gate #(.NBLK(NBLK)) u_slow (
      .raw       (raw_sync[g]),
      .en        (cfg_q[g].en),
      .pol       (cfg_q[g].pol),
      .blank_sel (cfg_q[g].blank[NBLK-1:0]),
      .blank_src (blank_src[g*NBLK +: NBLK]),
      .value     (slow_val[g])
    );

    assign cmp_out[g]                  = cfg_q[g].wout ? ^fast_val : fast_val[g];
    assign inp_sel[g*INP_W +: INP_W]   = cfg_q[g].wlink ? cfg_q[OTHER].inp : cfg_q[g].inp;
    assign inp_link[g]                 = cfg_q[g].wlink;
    assign inm_sel[g*INM_W +: INM_W]   = cfg_q[g].inm;
    assign hyst_sel[g*HYS_W +: HYS_W]  = cfg_q[g].hys;
    assign pwr_sel[g*PWR_W +: PWR_W]   = cfg_q[g].pwr;
    assign cmp_en[g]                   = cfg_q[g].en;
    assign ref_use[g]                  = cfg_q[g].en && (cfg_q[g].inm <= INM_REF_MAX);

    a_r6_blank_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      (|(cfg_q[g].blank[NBLK-1:0] & blank_src[g*NBLK +: NBLK]) && !cfg_q[g].wout)
        |-> !cmp_out[g]);
  end

  assign scaler_en = |ref_use;

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(i)) rdata_d = cfg_to_word(cfg_q[i], slow_val[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_d;
  end

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LIVE_BITS) == '0);

  a_r8_window_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[0].wout && cfg_q[1].wout) |-> (cmp_out[0] == cmp_out[1]));

  a_r10_scaler_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en == 2'b00) |-> !scaler_en);
endmodule

// File: tb/cmpw_ctrl_test.sv
module cmpw_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [0:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cmp_raw = '0;
  logic [5:0]  blank_src = '0;
  logic [1:0]  cmp_out;
  logic [3:0]  inp_sel;
  logic [1:0]  inp_link;
  logic [7:0]  inm_sel;
  logic [3:0]  hyst_sel;
  logic [3:0]  pwr_sel;
  logic [1:0]  cmp_en;
  logic        scaler_en;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_word [2];
  localparam logic [31:0] WMASK = 32'h81FF_CBF1;

  always #5 clk = ~clk;

  cmpw_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_raw(cmp_raw), .blank_src(blank_src), .cmp_out(cmp_out),
    .inp_sel(inp_sel), .inp_link(inp_link), .inm_sel(inm_sel),
    .hyst_sel(hyst_sel), .pwr_sel(pwr_sel), .cmp_en(cmp_en),
    .scaler_en(scaler_en)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_val(int ch, logic [1:0] raw, logic [5:0] blk);
    logic [31:0] w;
    logic p;
    logic m;
    w = m_word[ch];
    p = (w[0] & raw[ch]) ^ w[15];
    m = |(w[22:20] & blk[ch*3 +: 3]);
    return p & ~m;
  endfunction

  task automatic bus_write(int ch, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'(ch); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (!m_word[ch][31]) m_word[ch] = d & WMASK;
  endtask

  task automatic bus_read(int ch, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 1'(ch);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_word[0] = '0; m_word[1] = '0;
  endtask

  // raw held stable long enough to cross the synchronizer, then read back
  task automatic check_readback(int ch, string req);
    logic [31:0] d;
    logic [31:0] e;
    repeat (3) @(negedge clk);
    bus_read(ch, d);
    e = m_word[ch] | (32'(exp_val(ch, cmp_raw, blank_src)) << 30);
    chk(req, d, e);
  endtask

  task automatic check_comb();
    logic [1:0] v;
    logic [1:0] eo;
    logic [3:0] ei;
    logic       es;
    v[0] = exp_val(0, cmp_raw, blank_src);
    v[1] = exp_val(1, cmp_raw, blank_src);
    for (int c = 0; c < 2; c++) begin
      eo[c] = m_word[c][14] ? (v[0] ^ v[1]) : v[c];
      ei[c*2 +: 2] = m_word[c][11] ? m_word[1-c][9:8] : m_word[c][9:8];
    end
    es = (m_word[0][0] && m_word[0][7:4] <= 4'd3) || (m_word[1][0] && m_word[1][7:4] <= 4'd3);
    chk("R8 cmp_out", 32'(cmp_out), 32'(eo));
    chk("R9 inp_sel", 32'(inp_sel), 32'(ei));
    chk("R9 inp_link", 32'(inp_link), 32'({m_word[1][11], m_word[0][11]}));
    chk("R10 scaler_en", 32'(scaler_en), 32'(es));
    chk("R11 fields", {8'h0, inm_sel, hyst_sel, pwr_sel, 6'h0, cmp_en},
        {8'h0, m_word[1][7:4], m_word[0][7:4], m_word[1][17:16], m_word[0][17:16],
         m_word[1][19:18], m_word[0][19:18], 6'h0, m_word[1][0], m_word[0][0]});
  endtask

  task automatic drive(logic [1:0] r, logic [5:0] b);
    @(negedge clk);
    cmp_raw = r; blank_src = b;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    m_word[0] = '0; m_word[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(0, d); chk("R1 reset ch0", d, 32'h0);
    bus_read(1, d); chk("R1 reset ch1", d, 32'h0);
    check_comb();

    // R3 full field readback, reserved bits stay zero
    bus_write(0, 32'hFFFF_FFFE & ~32'h8000_0000);
    check_readback(0, "R3 fields/R1 reserved ch0");

    // R4 disabled channel: value equals polarity
    bus_write(0, 32'h0000_8000);
    drive(2'b01, 6'h00); check_comb();
    check_readback(0, "R4 disabled pol=1");
    chk("R4 cmp_out", 32'(cmp_out[0]), 32'h1);

    // R6 select bits 3 and 4 pick no source
    bus_write(0, 32'h0180_8000);
    drive(2'b00, 6'h3F); chk("R6 bits3/4 no source", 32'(cmp_out[0]), 32'h1);

    // R5 / R6 each valid select bit
    for (int b = 0; b < 3; b++) begin
      bus_write(1, 32'h0000_0001 | (32'h1 << (20 + b)));
      drive(2'b10, 6'h00); chk("R5 enabled raw passes", 32'(cmp_out[1]), 32'h1);
      drive(2'b10, 6'(1 << (3 + b))); chk("R6 blank bit", 32'(cmp_out[1]), 32'h0);
      drive(2'b10, 6'(7 & ~(1 << b)) << 3); chk("R6 other bit", 32'(cmp_out[1]), 32'h1);
    end

    // R8 window output
    bus_write(0, 32'h0000_4001);
    bus_write(1, 32'h0000_4001);
    drive(2'b01, 6'h00); chk("R8 window 01", 32'(cmp_out), 32'h3);
    drive(2'b11, 6'h00); chk("R8 window 11", 32'(cmp_out), 32'h0);
    check_comb();

    // R9 input link
    bus_write(0, 32'h0000_0A00);
    bus_write(1, 32'h0000_0100);
    drive(2'b00, 6'h00); check_comb();
    chk("R9 link uses other", 32'(inp_sel), 32'h5);

    // R7 synchronizer delay: visible two edges after a change, not before
    bus_write(0, 32'h0000_0001);
    drive(2'b00, 6'h00);
    repeat (3) @(negedge clk);
    cmp_raw = 2'b01;
    bus_read(0, d); chk("R7 not yet visible", 32'(d[30]), 32'h0);
    bus_read(0, d); chk("R7 visible", 32'(d[30]), 32'h1);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int ch;
      logic [31:0] w;
      ch = int'($urandom % 2);
      w = $urandom;
      w[31] = 1'b0;
      bus_write(ch, w);
      drive(2'($urandom), 6'($urandom));
      check_comb();
      if (it % 8 == 0) check_readback(ch, "R7 random readback");
    end

    // R2 lock
    bus_write(0, 32'h8000_8031);
    bus_write(0, 32'h0000_0000);
    bus_write(0, 32'h0123_4567);
    drive(2'b00, 6'h00);
    check_readback(0, "R2 locked word unchanged");
    chk("R2 lock bit", m_word[0][31] ? 32'h1 : 32'h0, 32'h1);
    check_comb();
    bus_write(1, 32'h0000_0031);
    check_readback(1, "R2 other channel writable");
    pulse_reset();
    bus_read(0, d); chk("R2 reset clears lock", d, 32'h0);
    bus_write(0, 32'h0000_0060);
    check_readback(0, "R2 writable after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule